// File: doc/BRIEF.md
# Two-Cell Bleed Balancing Controller

This block equalises two cells stacked in series by switching a resistive bleed path across whichever cell sits at the higher voltage. It takes a pair of sampled cell voltages, qualified by a valid strobe, and an enable. It drives one gate output per cell's bleed switch and a status flag that shows a balancing run is in progress. The bleed gates are independent of the charger's buck PWM.

The high-side bleed switch draws its gate bias from a bootstrap capacitor, so it must never be held on steadily. For that reason a bleed gate that is active is always pulsed at half duty over a parameterized period counted in clock cycles. Two thresholds give the start and stop decisions hysteresis, which keeps the block from chattering near balance. The decision is revisited only when a new valid sample pair arrives.

Top module: `cell_bleed_balancer`

## Requirements
- R1: While enabled and idle, a valid sample in which one cell exceeds the other by more than START_THR starts a bleed of the higher cell. Its gate goes high in the cycle after the sampling edge.
- R2: While a cell is bleeding, a valid sample in which that cell leads the other by less than STOP_THR ends the run. This includes the case where the other cell is now higher. From the next cycle both gates and active_o are low.
- R3: Hysteresis. When idle, a difference of START_THR or less starts nothing. When bleeding, a lead of at least STOP_THR keeps the run going.
- R4: An active gate is high for PWM_PERIOD/2 cycles and then low for PWM_PERIOD/2 cycles, repeating. Each run starts with the high phase, so a gate is never high for more than PWM_PERIOD/2 consecutive cycles.
- R5: At most one of bleed_a_o and bleed_b_o is high in any cycle.
- R6: With en_i low, both gates are low in that same cycle. The run is cleared at the next edge, and after re-enabling nothing bleeds until a new valid sample starts a run.
- R7: Cell voltage changes without smp_valid_i high have no effect on the outputs' mode.
- R8: After reset, bleed_a_o, bleed_b_o and active_o are low.
- R9: active_o is high exactly while a run is in progress, through both PWM phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Balancing enable |
| smp_valid_i | input | 1 | New sample pair present on the cell inputs |
| cell_a_v_i | input | VW | Sampled voltage of cell A (upper) |
| cell_b_v_i | input | VW | Sampled voltage of cell B (lower) |
| bleed_a_o | output | 1 | Bleed switch gate for cell A |
| bleed_b_o | output | 1 | Bleed switch gate for cell B |
| active_o | output | 1 | Balancing run in progress |

## Verification
The directed patterns are chosen to separate the cases that matter:
- Large positive and large negative differences tell the two cell directions apart.
- Differences just on each side of the start and stop thresholds, plus a difference that lies between them, separate the hysteresis from a single-threshold compare.
- An exactly equal pair checks that a tie starts nothing.
- Moving the voltages with the strobe low shows whether the block wrongly tracks raw inputs.
- Dropping the enable in mid-pulse shows whether the gates are forced low at once and the run is cleared.

Random sample pairs clustered around a common level then mix all of these transitions, including a reversal of the higher cell while a run is active. A reference model built from the requirements checks both gates and the status every cycle.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  typedef enum logic [1:0] {
    BAL_IDLE = 2'd0,
    BAL_A    = 2'd1,
    BAL_B    = 2'd2
  } bal_mode_e;
endpackage

// File: rtl/cbb_decide.sv
module cbb_decide
  import cbb_pkg::*;
#(
  parameter int VW        = 12,
  parameter int START_THR = 40,
  parameter int STOP_THR  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          smp_valid_i,
  input  logic [VW-1:0] cell_a_v_i,
  input  logic [VW-1:0] cell_b_v_i,
  output bal_mode_e     mode_o
);
  localparam int DW = VW + 1;
  localparam logic signed [DW-1:0] START_S = DW'(START_THR);
  localparam logic signed [DW-1:0] STOP_S  = DW'(STOP_THR);

  logic signed [DW-1:0] d_ab;
  bal_mode_e mode_q, mode_d;

  // signed A minus B, one extra bit so no wrap
  assign d_ab = $signed({1'b0, cell_a_v_i}) - $signed({1'b0, cell_b_v_i});

  always_comb begin
    mode_d = mode_q;
    if (smp_valid_i) begin
      unique case (mode_q)
        BAL_IDLE: begin
          if (d_ab > START_S)       mode_d = BAL_A;
          else if (d_ab < -START_S) mode_d = BAL_B;
        end
        BAL_A:   if (d_ab < STOP_S)  mode_d = BAL_IDLE;
        BAL_B:   if (d_ab > -STOP_S) mode_d = BAL_IDLE;
        default: mode_d = BAL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= BAL_IDLE;
    else if (!en_i) mode_q <= BAL_IDLE;
    else            mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cbb_pwm.sv
module cbb_pwm
  import cbb_pkg::*;
#(
  parameter int PWM_PERIOD = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  bal_mode_e mode_i,
  output logic      gate_a_o,
  output logic      gate_b_o
);
  localparam int CW   = (PWM_PERIOD > 2) ? $clog2(PWM_PERIOD) : 1;
  localparam int HALF = PWM_PERIOD / 2;

  logic [CW-1:0] cnt_q;
  logic          hi_phase;

  // phase counter held at zero while idle so each run opens with the high half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!en_i || mode_i == BAL_IDLE)    cnt_q <= '0;
    else if (cnt_q == CW'(PWM_PERIOD - 1))   cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end

  assign hi_phase = (cnt_q < CW'(HALF));
  assign gate_a_o = en_i && hi_phase && (mode_i == BAL_A);
  assign gate_b_o = en_i && hi_phase && (mode_i == BAL_B);
endmodule

// File: rtl/cell_bleed_balancer.sv
module cell_bleed_balancer
  import cbb_pkg::*;
#(
  parameter int VW         = 12,
  parameter int START_THR  = 40,
  parameter int STOP_THR   = 10,
  parameter int PWM_PERIOD = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          smp_valid_i,
  input  logic [VW-1:0] cell_a_v_i,
  input  logic [VW-1:0] cell_b_v_i,
  output logic          bleed_a_o,
  output logic          bleed_b_o,
  output logic          active_o
);
  bal_mode_e mode;

  cbb_decide #(
    .VW(VW), .START_THR(START_THR), .STOP_THR(STOP_THR)
  ) u_decide (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .smp_valid_i(smp_valid_i),
    .cell_a_v_i(cell_a_v_i), .cell_b_v_i(cell_b_v_i), .mode_o(mode)
  );

  cbb_pwm #(
    .PWM_PERIOD(PWM_PERIOD)
  ) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode),
    .gate_a_o(bleed_a_o), .gate_b_o(bleed_b_o)
  );

  assign active_o = (mode != BAL_IDLE);
endmodule

// File: rtl/cbb_checker.sv
module cbb_checker #(
  parameter int VW         = 12,
  parameter int START_THR  = 40,
  parameter int STOP_THR   = 10,
  parameter int PWM_PERIOD = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          smp_valid_i,
  input logic [VW-1:0] cell_a_v_i,
  input logic [VW-1:0] cell_b_v_i,
  input logic          bleed_a_o,
  input logic          bleed_b_o,
  input logic          active_o
);
  localparam int HALF = PWM_PERIOD / 2;
  localparam int RW   = $clog2(PWM_PERIOD + 2) + 1;

  logic [RW-1:0] run_a, run_b;
  int va, vb;
  assign va = int'(cell_a_v_i);
  assign vb = int'(cell_b_v_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_a <= '0;
      run_b <= '0;
    end else begin
      run_a <= !bleed_a_o ? '0 : (run_a > RW'(HALF) ? run_a : run_a + 1'b1);
      run_b <= !bleed_b_o ? '0 : (run_b > RW'(HALF) ? run_b : run_b + 1'b1);
    end
  end

  p_start_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && smp_valid_i && !active_o && (va > vb + START_THR)) |=> (bleed_a_o || !en_i));

  p_start_b_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && smp_valid_i && !active_o && (vb > va + START_THR)) |=> (bleed_b_o || !en_i));

  p_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && smp_valid_i && active_o && (va < vb + STOP_THR) && (vb < va + STOP_THR))
      |=> !active_o);

  p_no_hold_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_a <= RW'(HALF));

  p_no_hold_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_b <= RW'(HALF));

  p_one_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bleed_a_o, bleed_b_o}));

  p_en_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !smp_valid_i) |=> $stable(active_o));

  p_gate_in_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bleed_a_o || bleed_b_o) |-> active_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r8: assert (!bleed_a_o && !bleed_b_o && !active_o);
    end
  end
endmodule

bind cell_bleed_balancer cbb_checker #(
  .VW(VW), .START_THR(START_THR), .STOP_THR(STOP_THR), .PWM_PERIOD(PWM_PERIOD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .smp_valid_i(smp_valid_i),
  .cell_a_v_i(cell_a_v_i), .cell_b_v_i(cell_b_v_i),
  .bleed_a_o(bleed_a_o), .bleed_b_o(bleed_b_o), .active_o(active_o)
);

// File: tb/cell_bleed_balancer_tb_top.sv
`timescale 1ns/1ps
module cell_bleed_balancer_tb_top;
  localparam int VW = 12, START_THR = 40, STOP_THR = 10, PWM_PERIOD = 8;
  localparam int HALF = PWM_PERIOD / 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, vld = 1'b0;
  logic [VW-1:0] va = '0, vb = '0;
  logic ga, gb, act;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_mode = 0;  // 0 idle, 1 bleeding A, 2 bleeding B
  int m_cnt = 0;

  always #5 clk = ~clk;

  cell_bleed_balancer #(
    .VW(VW), .START_THR(START_THR), .STOP_THR(STOP_THR), .PWM_PERIOD(PWM_PERIOD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .smp_valid_i(vld),
    .cell_a_v_i(va), .cell_b_v_i(vb),
    .bleed_a_o(ga), .bleed_b_o(gb), .active_o(act)
  );

  function automatic int next_mode(int mode, int a, int b);
    int d = a - b;
    case (mode)
      0: return (d > START_THR) ? 1 : ((d < -START_THR) ? 2 : 0);
      1: return (d < STOP_THR) ? 0 : 1;
      default: return (d > -STOP_THR) ? 0 : 2;
    endcase
  endfunction

  task automatic chk(input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", what, got, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic ea, eb;
    ea = en && (m_mode == 1) && (m_cnt < HALF);
    eb = en && (m_mode == 2) && (m_cnt < HALF);
    chk(ga, ea, {tag, " bleed_a_o"});
    chk(gb, eb, {tag, " bleed_b_o"});
    chk(act, logic'(m_mode != 0), {tag, " active_o"});
  endtask

  // one clock: model follows the sampling edge, outputs checked at the falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    if (!en || m_mode == 0) m_cnt = 0;
    else m_cnt = (m_cnt == PWM_PERIOD - 1) ? 0 : m_cnt + 1;
    if (!en) m_mode = 0;
    else if (vld) m_mode = next_mode(m_mode, int'(va), int'(vb));
    @(negedge clk);
    compare(tag);
  endtask

  task automatic sample(input int a, input int b, input string tag);
    va = VW'(a); vb = VW'(b); vld = 1'b1;
    tick(tag);
    vld = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd1517));
    #12;
    @(negedge clk);
    chk(ga, 1'b0, "R8 reset bleed_a_o");
    chk(gb, 1'b0, "R8 reset bleed_b_o");
    chk(act, 1'b0, "R8 reset active_o");
    rst_n = 1'b1;
    en = 1'b1;
    idle(2, "R8");

    sample(2000, 2000, "R3 equal");                       // tie starts nothing
    sample(2040, 2000, "R3 at start thr");                // diff == START_THR: no start
    idle(2, "R3");
    sample(2041, 2000, "R1 start A");                     // diff START_THR+1
    idle(3 * PWM_PERIOD, "R4 pwm A");
    sample(2020, 2000, "R3 between thr");                 // lead 20 keeps run
    idle(5, "R9 run");
    va = 12'd3000; vb = 12'd100;                          // no strobe
    idle(4, "R7 no strobe");
    sample(2010, 2000, "R3 at stop thr");                 // lead == STOP_THR: continue
    idle(3, "R4");
    sample(2009, 2000, "R2 stop A");
    idle(3, "R2 stopped");

    sample(1000, 1100, "R1 start B");
    idle(2 * PWM_PERIOD + 1, "R4 pwm B");
    sample(1100, 1000, "R2 reversal");                    // other cell now higher
    idle(2, "R5");

    sample(500, 800, "R1 start B2");
    idle(2, "R4");
    en = 1'b0;
    @(negedge clk); #1;
    chk(gb, 1'b0, "R6 gate low with en low");
    tick("R6 en low");
    idle(3, "R6 en low");
    en = 1'b1;
    idle(3, "R6 reenable no run");
    sample(800, 500, "R1 start A2");
    idle(PWM_PERIOD, "R4");
    sample(800, 800, "R2 stop A2");
    idle(2, "R2");

    for (int i = 0; i < 4000; i++) begin
      base = 1500;
      vld = (($urandom % 4) == 0);
      en  = (($urandom % 32) != 0);
      va  = VW'(base + int'($urandom % 121) - 60);
      vb  = VW'(base + int'($urandom % 121) - 60);
      tick("R5 R9 random");
    end
    vld = 1'b0;
    en = 1'b1;
    idle(4, "R4 random tail");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule